// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home-side controller for a shared memory that is physically spread across nodes. For every memory block it keeps two things: a presence mask with one bit per processor, and an ownership flag. The flag, when set, means memory is stale and exactly one processor holds the only current copy in Modified state. Cache controllers send read misses, write misses and write-backs to this controller. It answers by sending data, invalidates or fetch messages. It takes in invalidate acknowledgements and owner data on a response channel, and it keeps the directory up to date.

All three channels use a valid/ready handshake. Each message carries a kind field, a block index and a processor id. The controller works on one read or write miss at a time, and `req_ready` stays low until that transaction has finished. A write-back finishes in the same cycle it is accepted. The interconnect and the remote caches are outside the block.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `out_valid` and `rsp_ready` are 0. Every block starts clean, with no sharers. Block b holds the value (b*37+5) mod 2^DATA_W.
- R2: A read miss (req_kind 0) on a clean block sends one DATA message (out_kind 0) to the requester, carrying the memory value. The requester becomes a sharer.
- R3: A read miss on an owned block sends FETCH (out_kind 2) to the owner. When the owner answers with OWNDATA (rsp_kind 1), memory takes that value and the block becomes clean. The requester is added as a sharer, the owner stays a sharer, and the controller sends no data message of its own.
- R4: A write miss (req_kind 1) on a clean block sends INV (out_kind 1) to each sharer in ascending id order. DATA goes out only after one ACK (rsp_kind 0) has arrived for every INV. After that, the requester is the sole owner.
- R5: The requester's own presence bit is never sent an INV and is not counted among the acknowledgements still owed.
- R6: A write miss on an owned block sends FETCH_INV (out_kind 3) to the owner. The owner's data is forwarded as DATA to the requester, ownership moves to the requester, and the old owner is no longer a sharer.
- R7: A write-back (req_kind 2) from the current owner writes memory and leaves the block clean with no sharers. A write-back from any other processor, or to a clean block, changes nothing.
- R8: After a read or write miss is accepted, `req_ready` is low until the transaction completes. A write-back leaves `req_ready` high.
- R9: While `out_valid` is high and `out_ready` is low, the outgoing message's kind, destination, block and data do not change.
- R10: A block marked owned always has exactly one presence bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_blk | input | BLK_W | Block index |
| req_src | input | PID_W | Requesting processor |
| req_data | input | DATA_W | Write-back data |
| out_valid | output | 1 | Outgoing message valid |
| out_ready | input | 1 | Network accepts outgoing message |
| out_kind | output | 2 | 0 DATA, 1 INV, 2 FETCH, 3 FETCH_INV |
| out_blk | output | BLK_W | Block index of message |
| out_dst | output | PID_W | Destination processor |
| out_data | output | DATA_W | Block value for DATA |
| rsp_valid | input | 1 | Response offered |
| rsp_ready | output | 1 | Controller accepts responses |
| rsp_kind | input | 1 | 0 ACK, 1 OWNDATA |
| rsp_src | input | PID_W | Responding processor |
| rsp_data | input | DATA_W | Owner data |

## Verification
Some properties are checked by assertions on every cycle. An owned block has a single presence bit. No INV is ever addressed to the requester. The acknowledgement count never goes below zero, and DATA for a write is never offered while acknowledgements are still owed. Outgoing messages stay stable under back-pressure, and the request port closes once a miss is accepted. Other behaviour can only be shown by the bench's scenarios, which track a model of the directory: the exact invalidate order, memory being updated from owner data and from write-backs, write-backs from non-owners being ignored, and the sharer sets seen across long sequences of mixed requests.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {REQ_RD = 2'd0, REQ_WR = 2'd1, REQ_WB = 2'd2} req_kind_t;
  typedef enum logic [1:0] {MSG_DATA = 2'd0, MSG_INV = 2'd1, MSG_FETCH = 2'd2, MSG_FETCH_INV = 2'd3} msg_kind_t;
  typedef enum logic {RSP_ACK = 1'b0, RSP_OWNDATA = 1'b1} rsp_kind_t;
  typedef enum logic [2:0] {ST_IDLE, ST_INVAL, ST_FETCH_SEND, ST_FETCH_WAIT, ST_DATA_SEND} ctl_state_t;
endpackage

// File: rtl/dir_store.sv
module dir_store #(
  parameter int NBLK   = 16,
  parameter int NPROC  = 4,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NBLK)-1:0] blk,
  output logic [NPROC-1:0]        rd_pres,
  output logic                    rd_dirty,
  output logic [DATA_W-1:0]       rd_data,
  input  logic                    wr_en,
  input  logic [NPROC-1:0]        wr_pres,
  input  logic                    wr_dirty,
  input  logic                    wr_data_en,
  input  logic [DATA_W-1:0]       wr_data
);
  logic [NPROC-1:0]  pres_q  [NBLK];
  logic              dirty_q [NBLK];
  logic [DATA_W-1:0] mem_q   [NBLK];

  assign rd_pres  = pres_q[blk];
  assign rd_dirty = dirty_q[blk];
  assign rd_data  = mem_q[blk];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) begin
        pres_q[b]  <= '0;
        dirty_q[b] <= 1'b0;
        mem_q[b]   <= DATA_W'(b * 37 + 5);
      end
    end else if (wr_en) begin
      pres_q[blk]  <= wr_pres;
      dirty_q[blk] <= wr_dirty;
      if (wr_data_en) mem_q[blk] <= wr_data;
    end
  end

  for (genvar g = 0; g < NBLK; g++) begin : g_owner_chk
    assert_single_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_q[g] |-> ($countones(pres_q[g]) == 1));
  end
endmodule

// File: rtl/dir_inv_tracker.sv
module dir_inv_tracker #(
  parameter int NPROC = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [NPROC-1:0]         load_mask,
  input  logic                     sent,
  input  logic                     ack,
  output logic                     pend_any,
  output logic [$clog2(NPROC)-1:0] next_dst,
  output logic                     done
);
  localparam int PID_W = $clog2(NPROC);
  localparam int CNT_W = $clog2(NPROC + 1);

  logic [NPROC-1:0] pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    next_dst = '0;
    for (int j = NPROC - 1; j >= 0; j--) begin
      if (pend_q[j]) next_dst = PID_W'(j);
    end
  end

  assign pend_any = |pend_q;
  assign done     = !pend_any && (cnt_q == '0);

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (load) begin
      pend_d = load_mask;
      cnt_d  = CNT_W'($countones(load_mask));
    end else begin
      if (sent) pend_d = pend_q & ~(NPROC'(1) << next_dst);
      if (ack)  cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assert_ack_within_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (cnt_q != '0));
  assert_sent_only_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sent |-> pend_any);
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int NBLK   = 16,
  parameter int NPROC  = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_kind,
  input  logic [$clog2(NBLK)-1:0]  req_blk,
  input  logic [$clog2(NPROC)-1:0] req_src,
  input  logic [DATA_W-1:0]        req_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [1:0]               out_kind,
  output logic [$clog2(NBLK)-1:0]  out_blk,
  output logic [$clog2(NPROC)-1:0] out_dst,
  output logic [DATA_W-1:0]        out_data,
  input  logic                     rsp_valid,
  output logic                     rsp_ready,
  input  logic                     rsp_kind,
  input  logic [$clog2(NPROC)-1:0] rsp_src,
  input  logic [DATA_W-1:0]        rsp_data
);
  import dir_pkg::*;
  localparam int BLK_W = $clog2(NBLK);
  localparam int PID_W = $clog2(NPROC);

  // reset: asserted asynchronously, released on the clock
  logic rs1_q, rstn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rstn  <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rstn  <= rs1_q;
    end
  end

  ctl_state_t        state_q, state_d;
  logic [BLK_W-1:0]  cur_blk_q;
  logic [PID_W-1:0]  cur_src_q, owner_q, owner_d;
  logic              cur_wr_q;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              cap_en, buf_en;

  logic [BLK_W-1:0]  st_blk;
  logic [NPROC-1:0]  rd_pres, wr_pres;
  logic              rd_dirty, wr_dirty, wr_en, wr_data_en;
  logic [DATA_W-1:0] rd_data, wr_data;

  logic             trk_load, trk_sent, trk_ack, trk_pend, trk_done;
  logic [PID_W-1:0] trk_next;
  logic [NPROC-1:0] req_bit, cur_bit;
  logic             own_pulse;

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_ready = (state_q == ST_INVAL) || (state_q == ST_FETCH_WAIT);
  assign st_blk    = req_ready ? req_blk : cur_blk_q;
  assign req_bit   = NPROC'(1) << req_src;
  assign cur_bit   = NPROC'(1) << cur_src_q;
  assign trk_sent  = (state_q == ST_INVAL) && out_valid && out_ready;
  assign trk_ack   = (state_q == ST_INVAL) && rsp_valid && (rsp_kind_t'(rsp_kind) == RSP_ACK);
  assign own_pulse = (state_q == ST_FETCH_WAIT) && rsp_valid &&
                     (rsp_kind_t'(rsp_kind) == RSP_OWNDATA) && (rsp_src == owner_q);

  dir_store #(.NBLK(NBLK), .NPROC(NPROC), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rstn), .blk(st_blk),
    .rd_pres(rd_pres), .rd_dirty(rd_dirty), .rd_data(rd_data),
    .wr_en(wr_en), .wr_pres(wr_pres), .wr_dirty(wr_dirty),
    .wr_data_en(wr_data_en), .wr_data(wr_data)
  );

  dir_inv_tracker #(.NPROC(NPROC)) u_trk (
    .clk(clk), .rst_n(rstn), .load(trk_load), .load_mask(rd_pres & ~req_bit),
    .sent(trk_sent), .ack(trk_ack), .pend_any(trk_pend), .next_dst(trk_next),
    .done(trk_done)
  );

  always_comb begin
    owner_d = '0;
    for (int j = NPROC - 1; j >= 0; j--) begin
      if (rd_pres[j]) owner_d = PID_W'(j);
    end
  end

  // next-state and directory update
  always_comb begin
    state_d    = state_q;
    cap_en     = 1'b0;
    buf_en     = 1'b0;
    buf_d      = rd_data;
    trk_load   = 1'b0;
    wr_en      = 1'b0;
    wr_pres    = rd_pres;
    wr_dirty   = rd_dirty;
    wr_data_en = 1'b0;
    wr_data    = req_data;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        case (req_kind_t'(req_kind))
          REQ_RD: begin
            cap_en  = 1'b1;
            buf_en  = 1'b1;
            state_d = rd_dirty ? ST_FETCH_SEND : ST_DATA_SEND;
          end
          REQ_WR: begin
            cap_en = 1'b1;
            buf_en = 1'b1;
            if (rd_dirty) state_d = ST_FETCH_SEND;
            else begin
              trk_load = 1'b1;
              state_d  = ST_INVAL;
            end
          end
          REQ_WB: if (rd_dirty && rd_pres[req_src]) begin
            wr_en      = 1'b1;
            wr_pres    = rd_pres & ~req_bit;
            wr_dirty   = 1'b0;
            wr_data_en = 1'b1;
          end
          default: ;
        endcase
      end
      ST_INVAL: if (trk_done) state_d = ST_DATA_SEND;
      ST_FETCH_SEND: if (out_ready) state_d = ST_FETCH_WAIT;
      ST_FETCH_WAIT: if (own_pulse) begin
        if (cur_wr_q) begin
          buf_en  = 1'b1;
          buf_d   = rsp_data;
          state_d = ST_DATA_SEND;
        end else begin
          wr_en      = 1'b1;
          wr_pres    = rd_pres | cur_bit;
          wr_dirty   = 1'b0;
          wr_data_en = 1'b1;
          wr_data    = rsp_data;
          state_d    = ST_IDLE;
        end
      end
      ST_DATA_SEND: if (out_ready) begin
        wr_en = 1'b1;
        if (cur_wr_q) begin
          wr_pres  = cur_bit;
          wr_dirty = 1'b1;
        end else begin
          wr_pres  = rd_pres | cur_bit;
        end
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      state_q   <= ST_IDLE;
      cur_blk_q <= '0;
      cur_src_q <= '0;
      cur_wr_q  <= 1'b0;
      owner_q   <= '0;
      buf_q     <= '0;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        cur_blk_q <= req_blk;
        cur_src_q <= req_src;
        cur_wr_q  <= (req_kind_t'(req_kind) == REQ_WR);
        owner_q   <= owner_d;
      end
      if (buf_en) buf_q <= buf_d;
    end
  end

  // outgoing message
  always_comb begin
    out_valid = 1'b0;
    out_kind  = MSG_DATA;
    out_dst   = cur_src_q;
    out_data  = buf_q;
    case (state_q)
      ST_INVAL: begin
        out_valid = trk_pend;
        out_kind  = MSG_INV;
        out_dst   = trk_next;
      end
      ST_FETCH_SEND: begin
        out_valid = 1'b1;
        out_kind  = cur_wr_q ? MSG_FETCH_INV : MSG_FETCH;
        out_dst   = owner_q;
      end
      ST_DATA_SEND: out_valid = 1'b1;
      default: ;
    endcase
  end
  assign out_blk = cur_blk_q;

  assert_hold_message_R9: assert property (@(posedge clk) disable iff (!rstn)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_dst) &&
                                   $stable(out_blk) && $stable(out_data)));
  assert_busy_after_miss_R8: assert property (@(posedge clk) disable iff (!rstn)
    (req_valid && req_ready && (req_kind == 2'd0 || req_kind == 2'd1)) |=> !req_ready);
  assert_no_self_inval_R5: assert property (@(posedge clk) disable iff (!rstn)
    (out_valid && out_kind == MSG_INV) |-> (out_dst != cur_src_q));
  assert_grant_after_acks_R4: assert property (@(posedge clk) disable iff (!rstn)
    (out_valid && out_kind == MSG_DATA && cur_wr_q) |-> trk_done);
endmodule

// File: tb/dir_home_ctrl_test.sv
module dir_home_ctrl_test;
  localparam int NB = 16, NP = 4, DW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, req_valid, req_ready, out_valid, out_ready, rsp_valid, rsp_ready, rsp_kind;
  logic [1:0]    req_kind, out_kind;
  logic [3:0]    req_blk, out_blk;
  logic [1:0]    req_src, out_dst, rsp_src;
  logic [DW-1:0] req_data, out_data, rsp_data;

  dir_home_ctrl #(.NBLK(NB), .NPROC(NP), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind), .req_blk(req_blk),
    .req_src(req_src), .req_data(req_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind), .out_blk(out_blk),
    .out_dst(out_dst), .out_data(out_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_src(rsp_src),
    .rsp_data(rsp_data)
  );

  int checks = 0, fails = 0, stamp = 0;
  logic [DW-1:0] mem_m [NB];
  logic [DW-1:0] own_m [NB];
  logic [NP-1:0] pres_m [NB];
  logic          dirty_m [NB];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int owner_of(input logic [NP-1:0] m);
    for (int j = 0; j < NP; j++) if (m[j]) return j;
    return 0;
  endfunction

  task automatic expect_out(input int kind, input int dst, input int blk, input int data,
                            input bit chkd, input int stall, input string req);
    int n = 0;
    logic [1:0] k0, d0;
    logic [DW-1:0] v0;
    while (!out_valid && n < 60) begin @(negedge clk); n++; end
    chk(out_valid, req, out_valid, 1);
    chk(out_kind == kind, req, out_kind, kind);
    chk(out_dst == dst, req, out_dst, dst);
    chk(out_blk == blk, req, out_blk, blk);
    if (chkd) chk(out_data == data, req, out_data, data);
    k0 = out_kind; d0 = out_dst; v0 = out_data;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(out_valid && out_kind == k0 && out_dst == d0 && out_data == v0, "R9", out_data, v0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic send_rsp(input logic kind, input int src, input int data);
    int n = 0;
    while (!rsp_ready && n < 60) begin @(negedge clk); n++; end
    rsp_valid = 1'b1; rsp_kind = kind; rsp_src = 2'(src); rsp_data = DW'(data);
    @(posedge clk);
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic issue(input int kind, input int blk, input int src, input int data);
    int n = 0;
    req_valid = 1'b1; req_kind = 2'(kind); req_blk = 4'(blk); req_src = 2'(src); req_data = DW'(data);
    while (!req_ready && n < 60) begin @(negedge clk); n++; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (!req_ready && n < 60) begin @(negedge clk); n++; end
    chk(req_ready, req, req_ready, 1);
  endtask

  task automatic do_rd(input int blk, input int src, input int stall, input string tag);
    int ow = owner_of(pres_m[blk]);
    if (dirty_m[blk] && ow == src) return;
    issue(0, blk, src, 0);
    chk(!req_ready, "R8", req_ready, 0);
    if (dirty_m[blk]) begin
      expect_out(2, ow, blk, 0, 1'b0, stall, "R3");
      send_rsp(1'b1, ow, own_m[blk]);
      chk(!out_valid, "R3", out_valid, 0);
      wait_idle("R3");
      mem_m[blk] = own_m[blk];
      dirty_m[blk] = 1'b0;
    end else begin
      expect_out(0, src, blk, mem_m[blk], 1'b1, stall, tag);
      wait_idle("R2");
    end
    pres_m[blk][src] = 1'b1;
  endtask

  task automatic do_wr(input int blk, input int src, input int stall);
    int ow = owner_of(pres_m[blk]);
    logic [NP-1:0] sh;
    if (dirty_m[blk] && ow == src) return;
    issue(1, blk, src, 0);
    chk(!req_ready, "R8", req_ready, 0);
    if (dirty_m[blk]) begin
      expect_out(3, ow, blk, 0, 1'b0, stall, "R6");
      send_rsp(1'b1, ow, own_m[blk]);
      expect_out(0, src, blk, own_m[blk], 1'b1, 0, "R6");
    end else begin
      sh = pres_m[blk] & ~(NP'(1) << src);
      for (int j = 0; j < NP; j++)
        if (sh[j]) expect_out(1, j, blk, 0, 1'b0, stall, pres_m[blk][src] ? "R5" : "R4");
      for (int j = 0; j < NP; j++)
        if (sh[j]) begin
          @(negedge clk);
          chk(!out_valid, "R4", out_valid, 0);
          send_rsp(1'b0, j, 0);
        end
      expect_out(0, src, blk, mem_m[blk], 1'b1, 0, "R4");
    end
    wait_idle("R8");
    pres_m[blk] = NP'(1) << src;
    dirty_m[blk] = 1'b1;
    own_m[blk] = DW'(stamp * 29 + blk + src);
    stamp++;
  endtask

  task automatic do_wb(input int blk, input int src, input int data);
    issue(2, blk, src, data);
    chk(req_ready, "R8", req_ready, 1);
    chk(!out_valid, "R7", out_valid, 0);
    if (dirty_m[blk] && owner_of(pres_m[blk]) == src) begin
      mem_m[blk] = DW'(data);
      dirty_m[blk] = 1'b0;
      pres_m[blk] = '0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] x;
    rst_n = 1'b0; req_valid = 1'b0; out_ready = 1'b0; rsp_valid = 1'b0;
    req_kind = '0; req_blk = '0; req_src = '0; req_data = '0;
    rsp_kind = 1'b0; rsp_src = '0; rsp_data = '0;
    for (int b = 0; b < NB; b++) begin
      mem_m[b] = DW'(b * 37 + 5); own_m[b] = '0; pres_m[b] = '0; dirty_m[b] = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1", out_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready, "R1", req_ready, 1);
    chk(!out_valid, "R1", out_valid, 0);
    chk(!rsp_ready, "R1", rsp_ready, 0);

    // every block read by every processor: reset contents and clean reads
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < NP; p++) do_rd(b, p, b % 3, p == 0 ? "R1" : "R2");

    // directed corner cases
    do_wr(0, 2, 2);        // upgrade by a sharer: three invalidates, own bit excluded
    do_rd(0, 1, 1, "R3");  // owned read: fetch from owner 2
    do_wr(0, 3, 0);        // sharers 1 and 2 invalidated
    do_wr(0, 1, 1);        // owned write: ownership moves 3 -> 1
    do_wr(5, 0, 0);
    do_wb(0, 2, 8'h11);    // non-owner write-back ignored
    do_wb(0, 1, 8'hC3);    // owner write-back
    do_rd(0, 0, 0, "R7");  // returns the written-back value
    do_wb(1, 3, 8'h77);    // clean block write-back ignored
    do_rd(1, 3, 0, "R7");
    do_wr(5, 3, 0);        // owned write, old owner 0 dropped
    do_wr(5, 0, 0);        // old owner 3 dropped, no invalidates (R6)

    // pseudo-random mixed traffic
    x = 32'h1234_5678;
    for (int i = 0; i < 900; i++) begin
      int op, blk, src;
      x = x * 32'd1103515245 + 32'd12345;
      op = int'(x[30:28]); blk = int'(x[19:16]); src = int'(x[23:22]);
      if (op < 3) do_rd(blk, src, int'(x[9:8]), "R2");
      else if (op < 6) do_wr(blk, src, int'(x[9:8]));
      else do_wb(blk, src, int'(x[7:0]));
    end
    for (int b = 0; b < NB; b++) do_rd(b, 2, 0, "R7");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule